// File: doc/BRIEF.md
# Debug Breakpoint Comparator

This block watches a processor's instruction-retire stream and its data-memory access stream. When a configured condition is met, it raises a break request toward a debug controller. It can break on any change of program flow (taken branch, jump, call, return, interrupt entry) and in single-step mode after every retired instruction. It also has four address comparators. Two of them match program addresses only. The other two are combined units. The last combined unit can be switched to watch data addresses, so the set works either as four program breakpoints or as three program breakpoints plus one data breakpoint.

Configuration is written through a small write-only register port. The output is a registered one-cycle pulse that comes with a one-hot cause vector. The cause vector flags every source that hit on the same event.

Top module: `brk_unit`

## Requirements
- R1: After reset, `brkPulse` and `brkCause` are 0 and all configuration is cleared, so no event produces a break until software enables one.
- R2: With the flow-change enable set (control bit 1), a retire with `retireJump` high sets cause bit 0. A sequential retire does not set it.
- R3: With the single-step enable set (control bit 2), every retire sets cause bit 1.
- R4: Program comparators 0 and 1 set cause bits 2 and 3 when a retiring PC equals their address register and their enable (control bits 6 and 7) is set. A cleared enable suppresses the match.
- R5: Combined comparator 0 (enable bit 8) always matches on retiring PCs and sets cause bit 4.
- R6: Combined comparator 1 (enable bit 9) sets cause bit 5. When the data-mode bit (control bit 3) is 0 it matches retiring PCs. When that bit is 1 it ignores PCs and matches data accesses whose address equals its register.
- R7: In data mode, a data access hits only if its direction is qualified: the read qualifier is control bit 4 (`dataWrite`=0) and the write qualifier is control bit 5 (`dataWrite`=1). Both bits set accepts both directions.
- R8: When several sources hit on the same cycle, one pulse carries every matching cause bit.
- R9: `brkPulse` is high for exactly the one cycle after a hitting event and is low otherwise. Back-to-back hitting events give back-to-back pulses. `brkCause` is 0 whenever `brkPulse` is low.
- R10: With the global enable (control bit 0) at 0, no source produces a break.
- R11: A configuration write affects events from the following cycle onward. An event in the same cycle as the write is judged against the old settings.
- R12: Register map on `cfgAddr`: 0 is control, and 1 to 4 hold the addresses of comparators 0 to 3. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | An instruction retires this cycle |
| retirePc | input | ADDR_W | Address of the retiring instruction |
| retireJump | input | 1 | The retiring instruction broke sequential flow |
| dataValid | input | 1 | A data-memory access occurs this cycle |
| dataAddr | input | ADDR_W | Data access address |
| dataWrite | input | 1 | 1 for a write access, 0 for a read |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | CFG_AW | Configuration register select |
| cfgWrData | input | CFG_W | Configuration write data |
| brkPulse | output | 1 | One-cycle break request |
| brkCause | output | 6 | One-hot-per-source cause vector |

## Verification
The assertions assume that `retireValid` and `dataValid` are single-cycle strobes, each standing for one event, and that every input is stable around the rising edge. The stimulus drives each event for exactly one cycle, one negative edge before the edge that samples it. It keeps configuration writes inside this contract, including the case where a write lands in the same cycle as an event. Each expected cause vector comes from a mirror of the register settings that is updated only after the event in that cycle has been judged.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NUM_CMP = 4;
  localparam int CAUSE_W = NUM_CMP + 2;
  localparam int CAUSE_FLOW = 0;
  localparam int CAUSE_STEP = 1;
  localparam int CAUSE_CMP0 = 2;

  // control register layout
  localparam int CTL_GEN   = 0;
  localparam int CTL_FLOW  = 1;
  localparam int CTL_STEP  = 2;
  localparam int CTL_DMODE = 3;
  localparam int CTL_RDQ   = 4;
  localparam int CTL_WRQ   = 5;
  localparam int CTL_EN_LO = 6;
  localparam int CTL_W     = CTL_EN_LO + NUM_CMP;

  typedef struct packed {
    logic               gEn;
    logic               flowEn;
    logic               stepEn;
    logic               dataMode;
    logic               rdQual;
    logic               wrQual;
    logic [NUM_CMP-1:0] cmpEn;
    logic [NUM_CMP-1:0] addrWr;
  } brkStrobe_t;
endpackage

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
#(
  parameter int CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CTL_W-1:0]  cfgWrData,
  output brkStrobe_t        strobes
);
  logic               gEnQ, flowEnQ, stepEnQ, dataModeQ, rdQualQ, wrQualQ;
  logic [NUM_CMP-1:0] cmpEnQ;
  logic               ctlSel;
  logic [NUM_CMP-1:0] addrSel;

  assign ctlSel = cfgWrEn && (cfgAddr == '0);

  always_comb begin
    for (int k = 0; k < NUM_CMP; k++) begin
      addrSel[k] = cfgWrEn && (cfgAddr == CFG_AW'(k + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gEnQ      <= 1'b0;
      flowEnQ   <= 1'b0;
      stepEnQ   <= 1'b0;
      dataModeQ <= 1'b0;
      rdQualQ   <= 1'b0;
      wrQualQ   <= 1'b0;
      cmpEnQ    <= '0;
    end else if (ctlSel) begin
      gEnQ      <= cfgWrData[CTL_GEN];
      flowEnQ   <= cfgWrData[CTL_FLOW];
      stepEnQ   <= cfgWrData[CTL_STEP];
      dataModeQ <= cfgWrData[CTL_DMODE];
      rdQualQ   <= cfgWrData[CTL_RDQ];
      wrQualQ   <= cfgWrData[CTL_WRQ];
      cmpEnQ    <= cfgWrData[CTL_EN_LO +: NUM_CMP];
    end
  end

  always_comb begin
    strobes.gEn      = gEnQ;
    strobes.flowEn   = flowEnQ;
    strobes.stepEn   = stepEnQ;
    strobes.dataMode = dataModeQ;
    strobes.rdQual   = rdQualQ;
    strobes.wrQual   = wrQualQ;
    strobes.cmpEn    = cmpEnQ;
    strobes.addrWr   = addrSel;
  end

  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctlSel |=> (strobes.gEn == $past(cfgWrData[CTL_GEN]))); // R12
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable({gEnQ, flowEnQ, stepEnQ, dataModeQ, rdQualQ, wrQualQ, cmpEnQ})); // R11
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctlSel, addrSel})); // R12
endmodule

// File: rtl/brk_dpath.sv
module brk_dpath
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  brkStrobe_t         strobes,
  input  logic [ADDR_W-1:0]  wrData,
  input  logic               retireValid,
  input  logic [ADDR_W-1:0]  retirePc,
  input  logic               retireJump,
  input  logic               dataValid,
  input  logic [ADDR_W-1:0]  dataAddr,
  input  logic               dataWrite,
  output logic               brkPulse,
  output logic [CAUSE_W-1:0] brkCause
);
  logic [ADDR_W-1:0]  cmpAddr [NUM_CMP];
  logic [NUM_CMP-1:0] cmpHit;
  logic               flowHit, stepHit;
  logic [CAUSE_W-1:0] rawHits, gatedHits;
  logic               pulseQ;
  logic [CAUSE_W-1:0] causeQ;

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_CMP; k++) begin
      if (!rstN) begin
        cmpAddr[k] <= '0;
      end else if (strobes.addrWr[k]) begin
        cmpAddr[k] <= wrData;
      end
    end
  end

  genvar i;
  generate
    for (i = 0; i < NUM_CMP; i++) begin : gCmp
      logic pcMatch;
      assign pcMatch = retireValid && (retirePc == cmpAddr[i]);
      if (i == NUM_CMP - 1) begin : gDual
        logic dirOk, dataMatch;
        assign dirOk     = dataWrite ? strobes.wrQual : strobes.rdQual;
        assign dataMatch = dataValid && (dataAddr == cmpAddr[i]) && dirOk;
        assign cmpHit[i] = strobes.cmpEn[i] &&
                           (strobes.dataMode ? dataMatch : pcMatch);
      end else begin : gProg
        assign cmpHit[i] = strobes.cmpEn[i] && pcMatch;
      end
    end
  endgenerate

  assign flowHit   = strobes.flowEn && retireValid && retireJump;
  assign stepHit   = strobes.stepEn && retireValid;
  assign rawHits   = {cmpHit, stepHit, flowHit};
  assign gatedHits = strobes.gEn ? rawHits : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseQ <= 1'b0;
      causeQ <= '0;
    end else begin
      pulseQ <= |gatedHits;
      causeQ <= gatedHits;
    end
  end

  assign brkPulse = pulseQ;
  assign brkCause = causeQ;

  AST_PULSE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    brkPulse |-> $past(retireValid || dataValid)); // R9
  AST_QUIET_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !brkPulse |-> (brkCause == '0)); // R9
  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.gEn |=> !brkPulse); // R10
  AST_STEP_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.gEn && strobes.stepEn && retireValid) |=> (brkPulse && brkCause[CAUSE_STEP])); // R3
  AST_DMODE_NO_PC: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.dataMode && !dataValid) |=> !brkCause[CAUSE_W-1]); // R6
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CFG_W  = 16,
  parameter int CFG_AW = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               retireValid,
  input  logic [ADDR_W-1:0]  retirePc,
  input  logic               retireJump,
  input  logic               dataValid,
  input  logic [ADDR_W-1:0]  dataAddr,
  input  logic               dataWrite,
  input  logic               cfgWrEn,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]   cfgWrData,
  output logic               brkPulse,
  output logic [CAUSE_W-1:0] brkCause
);
  brkStrobe_t strobes;

  brk_ctrl #(.CFG_AW(CFG_AW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData[CTL_W-1:0]),
    .strobes   (strobes)
  );

  brk_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (cfgWrData[ADDR_W-1:0]),
    .retireValid (retireValid),
    .retirePc    (retirePc),
    .retireJump  (retireJump),
    .dataValid   (dataValid),
    .dataAddr    (dataAddr),
    .dataWrite   (dataWrite),
    .brkPulse    (brkPulse),
    .brkCause    (brkCause)
  );
endmodule

// File: tb/brk_unit_tb.sv
module brk_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        retireValid = 0, retireJump = 0, dataValid = 0, dataWrite = 0;
  logic [15:0] retirePc = '0, dataAddr = '0, cfgWrData = '0;
  logic        cfgWrEn = 0;
  logic [2:0]  cfgAddr = '0;
  logic        brkPulse;
  logic [5:0]  brkCause;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  int         qStamp[$];
  logic [5:0] qCause[$];
  string      qTag[$];

  logic [9:0]  mCtrl = '0;
  logic [15:0] mAddr [4];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  brk_unit u_dut (
    .clk(clk), .rstN(rstN),
    .retireValid(retireValid), .retirePc(retirePc), .retireJump(retireJump),
    .dataValid(dataValid), .dataAddr(dataAddr), .dataWrite(dataWrite),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .brkPulse(brkPulse), .brkCause(brkCause)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] model();
    logic [5:0] c = '0;
    if (!mCtrl[0]) return '0;
    if (retireValid && retireJump && mCtrl[1]) c[0] = 1'b1;
    if (retireValid && mCtrl[2]) c[1] = 1'b1;
    for (int k = 0; k < 3; k++)
      if (retireValid && mCtrl[6+k] && retirePc == mAddr[k]) c[2+k] = 1'b1;
    if (mCtrl[9]) begin
      if (!mCtrl[3]) begin
        if (retireValid && retirePc == mAddr[3]) c[5] = 1'b1;
      end else if (dataValid && dataAddr == mAddr[3] && (dataWrite ? mCtrl[5] : mCtrl[4])) begin
        c[5] = 1'b1;
      end
    end
    return c;
  endfunction

  // driver: inputs already set at a negedge; push expectation, advance one cycle
  task automatic tick(input string tag);
    qStamp.push_back(cyc);
    qCause.push_back(model());
    qTag.push_back(tag);
    if (cfgWrEn) begin
      if (cfgAddr == 3'd0) mCtrl = cfgWrData[9:0];
      else if (cfgAddr <= 3'd4) mAddr[cfgAddr-1] = cfgWrData;
    end
    @(negedge clk);
    retireValid = 0; retireJump = 0; dataValid = 0; dataWrite = 0; cfgWrEn = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
    cfgWrEn = 1; cfgAddr = a; cfgWrData = d;
    tick(tag);
  endtask

  task automatic ret(input logic [15:0] pc, input bit jmp, input string tag);
    retireValid = 1; retirePc = pc; retireJump = jmp;
    tick(tag);
  endtask

  task automatic dacc(input logic [15:0] a, input bit w, input string tag);
    dataValid = 1; dataAddr = a; dataWrite = w;
    tick(tag);
  endtask

  // monitor: compare each expectation one cycle after its event
  always @(negedge clk) begin
    if (qStamp.size() > 0 && cyc > qStamp[0]) begin
      logic [5:0] e;
      string t;
      void'(qStamp.pop_front());
      e = qCause.pop_front();
      t = qTag.pop_front();
      check(brkCause == e && brkPulse == (e != 0), t, {brkPulse, brkCause}, {(e != 0), e});
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) mAddr[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(brkPulse == 0 && brkCause == 0, "R1 reset outputs", {brkPulse, brkCause}, 0);
    rstN = 1;
    ret(16'h0000, 1, "R1 no break after reset");
    // R11: write and event in the same cycle use old config
    cfgWrEn = 1; cfgAddr = 0; cfgWrData = 16'h0003;
    retireValid = 1; retireJump = 1; retirePc = 16'h10;
    tick("R11 same-cycle write");
    ret(16'h12, 1, "R2 flow change");
    ret(16'h13, 0, "R2 sequential");
    wr(0, 16'h0005, "R3 cfg");
    ret(16'h20, 0, "R3 step");
    ret(16'h21, 0, "R9 back-to-back step");
    ret(16'h22, 1, "R9 back-to-back step");
    tick("R9 idle quiet");
    wr(1, 16'h0100, "R12 addr0");
    wr(2, 16'h0200, "R12 addr1");
    wr(3, 16'h0300, "R12 addr2");
    wr(4, 16'h0400, "R12 addr3");
    wr(0, 16'h03C1, "R4 cfg");
    ret(16'h0100, 0, "R4 cmp0");
    ret(16'h0200, 0, "R4 cmp1");
    ret(16'h0300, 0, "R5 comb0");
    ret(16'h0400, 0, "R6 comb1 pc mode");
    ret(16'h0500, 0, "R4 no match");
    dacc(16'h0400, 0, "R6 pc mode ignores data");
    wr(0, 16'h0381, "R4 cfg");
    ret(16'h0100, 0, "R4 disabled cmp0");
    wr(0, 16'h03D9, "R7 cfg read");
    ret(16'h0400, 0, "R6 data mode ignores pc");
    dacc(16'h0400, 0, "R7 read hit");
    dacc(16'h0400, 1, "R7 write unqualified");
    dacc(16'h0401, 0, "R6 data miss");
    wr(0, 16'h03E9, "R7 cfg write");
    dacc(16'h0400, 1, "R7 write hit");
    dacc(16'h0400, 0, "R7 read unqualified");
    wr(0, 16'h03F9, "R7 cfg both");
    dacc(16'h0400, 0, "R7 both read");
    dacc(16'h0400, 1, "R7 both write");
    wr(0, 16'h03C7, "R8 cfg");
    ret(16'h0100, 1, "R8 flow+step+cmp0");
    wr(0, 16'h03DF, "R8 cfg data");
    retireValid = 1; retirePc = 16'h0300; dataValid = 1; dataAddr = 16'h0400;
    tick("R8 pc and data same cycle");
    wr(0, 16'h03C6, "R10 cfg");
    ret(16'h0100, 1, "R10 global off");
    dacc(16'h0400, 0, "R10 global off data");
    wr(0, 16'h0005, "R12 cfg");
    wr(7, 16'h0000, "R12 unmapped write");
    wr(5, 16'h0000, "R12 unmapped write");
    ret(16'h0600, 0, "R12 control unchanged");
    tick("R9 drain");
    tick("R9 drain");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule